// File: doc/BRIEF.md
# Load/Store Request Sequencer

This block sits between the load/store port of an execution pipeline and a data cache with an address-translation unit beside it. It takes one request at a time: a load, a store, a single-precision load, or a TLB invalidate. Each request carries an address, a byte-lane mask and store data. It turns the request into one cache access, or two when the lanes run past the end of a data word, and waits for the cache to answer.

Each cache access starts with a request level held inside the block. The cache sees only a one-cycle pulse taken from the rising edge of that level. When the cache reports an error, the block does one of two things. If the error is a paradox error, it raises an exception at once. For any other error it hands the address to the translation unit and, once translation succeeds, sends the same cache access again. Loads in a fixed peripheral window are marked uncached. Store data goes out one cycle after the pulse, and the data bus is held at zero at all other times. A fault status word and a fault address are captured whenever an exception ends a request.

Top module: `lsu_ctrl_fsm`

## Requirements
- R1: After reset, `req_ready` is 1, while `done`, `dc_valid`, `dc_wdata`, `fault_status` and `fault_addr` are all zero.
- R2: A request accepted in IDLE gives exactly one cycle of `dc_valid` in the next cycle. `dc_valid` is never high in two consecutive cycles. `dc_load` is 1 for `req_kind` 0 (load) and 2 (single-precision load), and 0 for 1 (store).
- R3: For an access that fits in one data word, `dc_addr` equals the request address and `dc_sel` equals the mask moved up by the address's byte offset (address bits [2:0]). `done` is high for exactly one cycle, the cycle after the acknowledge. `req_ready` returns in the cycle after that.
- R4: When the moved-up mask reaches past lane 7, a second pulse follows two cycles after the first acknowledge. It carries the address of the next 8-byte word (address with bits [2:0] cleared, plus 8) and the lanes that spilled over. An access that does not spill over produces no second pulse.
- R5: `dc_nc` is 1 during a load or single-precision load whose address bits [31:28] equal 0xC. It is 0 for a store in that window and for any access outside it.
- R6: In the cycle after each store pulse, `dc_wdata` holds the store data moved up by 8 times the byte offset, taking the half that belongs to the current access. `dc_wdata` is zero in every cycle not preceded by an active store access.
- R7: A cache error with `dc_paradox` set raises `exc_happened` in the same cycle and does not raise `mmu_req`. The unit then returns to IDLE without `done`. `fault_addr` receives the access address. `fault_status` becomes zero except bit 25 (1 for a store) and bit 28 (1).
- R8: A cache error without `dc_paradox` raises `mmu_req` for one cycle, with `mmu_addr` set to the access address. The unit then waits for the translation unit and issues no pulse while it waits. A `mmu_done` without `mmu_err` gives a new pulse to the same address in the next cycle, and the request then completes normally.
- R9: A `mmu_err` while waiting for translation returns the unit to IDLE without `done`. `fault_addr` receives the access address. `fault_status` becomes zero except bit 25 (1 for a store).
- R10: `exc_happened` is `dc_err` OR `mmu_err` at all times. The invalid, bad-tree, permission, reference/change and segment flags always equal the matching translation-unit inputs.
- R11: A single-precision load (`req_kind` 2) inserts one write-back cycle, so `done` comes two cycles after the last acknowledge.
- R12: A TLB invalidate (`req_kind` 3) issues no cache pulse. It holds `mmu_tlbie` high from the cycle after acceptance until `mmu_done`, and raises `done` in the cycle after `mmu_done`.
- R13: `req_valid` is ignored while the unit is busy. No extra pulse is issued and `dc_addr` keeps the address of the current request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request offered |
| req_kind | input | 2 | 0 load, 1 store, 2 single-precision load, 3 TLB invalidate |
| req_addr | input | ADDR_W | Request byte address |
| req_mask | input | DATA_W/8 | Byte lanes of the access, counted from the address |
| req_wdata | input | DATA_W | Store data, lane 0 is the addressed byte |
| req_ready | output | 1 | Unit is idle and takes a request |
| done | output | 1 | One-cycle completion strobe |
| dc_valid | output | 1 | One-cycle cache request pulse |
| dc_load | output | 1 | Access is a read |
| dc_nc | output | 1 | Access must bypass the cache |
| dc_addr | output | ADDR_W | Address of the current access |
| dc_sel | output | DATA_W/8 | Byte lanes of the current access |
| dc_wdata | output | DATA_W | Registered store data |
| dc_ack | input | 1 | Cache finished the access |
| dc_err | input | 1 | Cache reports an error |
| dc_paradox | input | 1 | Error cannot be solved by translation |
| mmu_req | output | 1 | One-cycle translation request |
| mmu_tlbie | output | 1 | TLB invalidate in progress |
| mmu_addr | output | ADDR_W | Address sent to the translation unit |
| mmu_done | input | 1 | Translation unit finished |
| mmu_err | input | 1 | Translation failed |
| mmu_invalid | input | 1 | No valid translation |
| mmu_badtree | input | 1 | Malformed table |
| mmu_perm_err | input | 1 | Permission fault |
| mmu_rc_err | input | 1 | Reference/change fault |
| mmu_seg_err | input | 1 | Segment fault |
| exc_happened | output | 1 | Exception raised |
| exc_invalid | output | 1 | Forwarded invalid flag |
| exc_badtree | output | 1 | Forwarded bad-tree flag |
| exc_perm_err | output | 1 | Forwarded permission flag |
| exc_rc_err | output | 1 | Forwarded reference/change flag |
| exc_seg_err | output | 1 | Forwarded segment flag |
| fault_status | output | FS_W | Captured fault status word |
| fault_addr | output | ADDR_W | Captured fault address |

## Verification
The transfer path is tried with the following patterns, and each one tells a different case apart:
- Full-word loads, which shows a correct address from a wrong lane shift.
- Half-word stores at offsets that stay inside a word and at offsets that spill over, which shows a missing or misplaced second access and a wrong data half.
- Loads and stores inside the 0xC window, which shows a window decode that also wrongly catches stores.
- Single-precision loads, both aligned and split, which shows the write-back cycle inserted on the right path.

Directed cases then separate the two error kinds by whether `mmu_req` rises and whether a retry pulse follows. They also cover a translation failure that overwrites a status word left from an earlier paradox fault, and a request offered while the unit is busy.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SECOND = 3'd1,
    ST_ACKW   = 3'd2,
    ST_MMU    = 3'd3,
    ST_TLBIE  = 3'd4,
    ST_SPWB   = 3'd5,
    ST_DONE   = 3'd6
  } lsu_state_e;

  typedef enum logic [1:0] {
    K_LOAD    = 2'd0,
    K_STORE   = 2'd1,
    K_LOAD_SP = 2'd2,
    K_INVAL   = 2'd3
  } lsu_kind_e;

  localparam int FS_BIT_STORE   = 63 - 38;
  localparam int FS_BIT_PARADOX = 63 - 35;
  localparam logic [3:0] NC_WINDOW = 4'hC;

endpackage

// File: rtl/lsu_lane_split.sv
module lsu_lane_split #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [DATA_W/8-1:0] lane_mask,
  input  logic [DATA_W-1:0]   store_data,
  input  logic                upper_half,
  output logic [ADDR_W-1:0]   part_addr,
  output logic [DATA_W/8-1:0] part_sel,
  output logic [DATA_W-1:0]   part_data,
  output logic                crosses
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int IDX_W = ADDR_W - OFF_W;
  localparam logic [IDX_W-1:0] ONE_WORD = 1;

  function automatic logic [2*LANES-1:0] spread_mask(input logic [LANES-1:0] m,
                                                     input logic [OFF_W-1:0] off);
    return {{LANES{1'b0}}, m} << off;
  endfunction

  function automatic logic [2*DATA_W-1:0] spread_data(input logic [DATA_W-1:0] d,
                                                      input logic [OFF_W-1:0] off);
    return {{DATA_W{1'b0}}, d} << {off, 3'b000};
  endfunction

  logic [OFF_W-1:0]    off;
  logic [IDX_W-1:0]    word_next;
  logic [2*LANES-1:0]  wide_sel;
  logic [2*DATA_W-1:0] wide_data;

  assign off       = base_addr[OFF_W-1:0];
  assign word_next = base_addr[ADDR_W-1:OFF_W] + ONE_WORD;
  assign wide_sel  = spread_mask(lane_mask, off);
  assign wide_data = spread_data(store_data, off);

  assign crosses   = |wide_sel[2*LANES-1:LANES];
  assign part_addr = upper_half ? {word_next, {OFF_W{1'b0}}} : base_addr;
  assign part_sel  = upper_half ? wide_sel[2*LANES-1:LANES] : wide_sel[LANES-1:0];
  assign part_data = upper_half ? wide_data[2*DATA_W-1:DATA_W] : wide_data[DATA_W-1:0];
endmodule

// File: rtl/lsu_edge_pulse.sv
module lsu_edge_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign pulse = level & ~level_q;
endmodule

// File: rtl/lsu_fault_regs.sv
module lsu_fault_regs #(
  parameter int ADDR_W = 64,
  parameter int FS_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              was_store,
  input  logic              paradox,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [FS_W-1:0]   status,
  output logic [ADDR_W-1:0] fault_addr
);
  import lsu_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status     <= '0;
      fault_addr <= '0;
    end else if (capture) begin
      status                 <= '0;
      status[FS_BIT_STORE]   <= was_store;
      status[FS_BIT_PARADOX] <= paradox;
      fault_addr             <= addr_in;
    end
  end
endmodule

// File: rtl/lsu_ctrl_fsm.sv
module lsu_ctrl_fsm #(
  parameter int ADDR_W       = 64,
  parameter int DATA_W       = 64,
  parameter int FS_W         = 64,
  parameter bit UNCACHED_ALL = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_kind,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W/8-1:0] req_mask,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                req_ready,
  output logic                done,
  output logic                dc_valid,
  output logic                dc_load,
  output logic                dc_nc,
  output logic [ADDR_W-1:0]   dc_addr,
  output logic [DATA_W/8-1:0] dc_sel,
  output logic [DATA_W-1:0]   dc_wdata,
  input  logic                dc_ack,
  input  logic                dc_err,
  input  logic                dc_paradox,
  output logic                mmu_req,
  output logic                mmu_tlbie,
  output logic [ADDR_W-1:0]   mmu_addr,
  input  logic                mmu_done,
  input  logic                mmu_err,
  input  logic                mmu_invalid,
  input  logic                mmu_badtree,
  input  logic                mmu_perm_err,
  input  logic                mmu_rc_err,
  input  logic                mmu_seg_err,
  output logic                exc_happened,
  output logic                exc_invalid,
  output logic                exc_badtree,
  output logic                exc_perm_err,
  output logic                exc_rc_err,
  output logic                exc_seg_err,
  output logic [FS_W-1:0]     fault_status,
  output logic [ADDR_W-1:0]   fault_addr
);
  import lsu_pkg::*;

  localparam int LANES = DATA_W / 8;

  lsu_state_e        st, st_nxt;
  lsu_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  mask_q;
  logic [DATA_W-1:0] data_q;
  logic              hi_q;
  logic              req_active, req_active_nxt;
  logic [DATA_W-1:0] wdata_q;

  logic              is_load, is_store;
  logic [ADDR_W-1:0] part_addr;
  logic [LANES-1:0]  part_sel;
  logic [DATA_W-1:0] part_data;
  logic              crosses;

  // named internal events
  logic ev_accept, ev_ack, ev_err_paradox, ev_err_retry;
  logic ev_mmu_ok, ev_mmu_fail, ev_split_more, wvalid;

  assign is_load  = (kind_q == K_LOAD) || (kind_q == K_LOAD_SP);
  assign is_store = (kind_q == K_STORE);

  assign ev_accept      = (st == ST_IDLE) && req_valid;
  assign ev_ack         = (st == ST_ACKW) && dc_ack && !dc_err;
  assign ev_err_paradox = (st == ST_ACKW) && dc_err && dc_paradox;
  assign ev_err_retry   = (st == ST_ACKW) && dc_err && !dc_paradox;
  assign ev_mmu_ok      = (st == ST_MMU) && mmu_done && !mmu_err;
  assign ev_mmu_fail    = (st == ST_MMU) && mmu_err;
  assign ev_split_more  = ev_ack && !hi_q && crosses;
  assign wvalid         = (st == ST_ACKW) && req_active && is_store;

  lsu_lane_split #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_split (
    .base_addr  (addr_q),
    .lane_mask  (mask_q),
    .store_data (data_q),
    .upper_half (hi_q),
    .part_addr  (part_addr),
    .part_sel   (part_sel),
    .part_data  (part_data),
    .crosses    (crosses)
  );

  lsu_edge_pulse u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .level (req_active),
    .pulse (dc_valid)
  );

  lsu_fault_regs #(.ADDR_W(ADDR_W), .FS_W(FS_W)) u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (ev_err_paradox | ev_mmu_fail),
    .was_store  (is_store),
    .paradox    (ev_err_paradox),
    .addr_in    (part_addr),
    .status     (fault_status),
    .fault_addr (fault_addr)
  );

  always_comb begin
    st_nxt         = st;
    req_active_nxt = req_active;
    unique case (st)
      ST_IDLE: if (ev_accept) begin
        if (lsu_kind_e'(req_kind) == K_INVAL) st_nxt = ST_TLBIE;
        else begin
          st_nxt         = ST_ACKW;
          req_active_nxt = 1'b1;
        end
      end
      ST_SECOND: begin
        st_nxt         = ST_ACKW;
        req_active_nxt = 1'b1;
      end
      ST_ACKW: begin
        if (ev_err_paradox) begin
          st_nxt         = ST_IDLE;
          req_active_nxt = 1'b0;
        end else if (ev_err_retry) begin
          st_nxt         = ST_MMU;
          req_active_nxt = 1'b0;
        end else if (ev_ack) begin
          req_active_nxt = 1'b0;
          if (ev_split_more)            st_nxt = ST_SECOND;
          else if (kind_q == K_LOAD_SP) st_nxt = ST_SPWB;
          else                          st_nxt = ST_DONE;
        end
      end
      ST_MMU: begin
        if (ev_mmu_fail) st_nxt = ST_IDLE;
        else if (ev_mmu_ok) begin
          st_nxt         = ST_ACKW;
          req_active_nxt = 1'b1;
        end
      end
      ST_TLBIE: if (mmu_done) st_nxt = ST_DONE;
      ST_SPWB:  st_nxt = ST_DONE;
      ST_DONE:  st_nxt = ST_IDLE;
      default:  st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      req_active <= 1'b0;
      kind_q     <= K_LOAD;
      addr_q     <= '0;
      mask_q     <= '0;
      data_q     <= '0;
      hi_q       <= 1'b0;
      wdata_q    <= '0;
    end else begin
      st         <= st_nxt;
      req_active <= req_active_nxt;
      if (ev_accept) begin
        kind_q <= lsu_kind_e'(req_kind);
        addr_q <= req_addr;
        mask_q <= req_mask;
        data_q <= req_wdata;
        hi_q   <= 1'b0;
      end else if (ev_split_more) begin
        hi_q <= 1'b1;
      end
      wdata_q <= wvalid ? part_data : '0;
    end
  end

  generate
    if (UNCACHED_ALL) begin : g_nc_all
      assign dc_nc = 1'b1;
    end else begin : g_nc_window
      assign dc_nc = is_load && (addr_q[31:28] == NC_WINDOW);
    end
  endgenerate

  assign req_ready = (st == ST_IDLE);
  assign done      = (st == ST_DONE);
  assign dc_load   = is_load;
  assign dc_addr   = part_addr;
  assign dc_sel    = part_sel;
  assign dc_wdata  = wdata_q;
  assign mmu_req   = ev_err_retry;
  assign mmu_tlbie = (st == ST_TLBIE);
  assign mmu_addr  = part_addr;

  assign exc_happened = dc_err | mmu_err;
  assign exc_invalid  = mmu_invalid;
  assign exc_badtree  = mmu_badtree;
  assign exc_perm_err = mmu_perm_err;
  assign exc_rc_err   = mmu_rc_err;
  assign exc_seg_err  = mmu_seg_err;
endmodule

// File: rtl/lsu_ctrl_checks.sv
module lsu_ctrl_checks #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int FS_W   = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input lsu_pkg::lsu_state_e  st,
  input logic                 dc_valid,
  input logic                 done,
  input logic                 req_ready,
  input logic                 dc_load,
  input logic                 dc_nc,
  input logic [ADDR_W-1:0]    addr_q,
  input logic [DATA_W-1:0]    dc_wdata,
  input logic                 wvalid,
  input logic                 ev_err_paradox,
  input logic                 ev_err_retry,
  input logic                 mmu_done,
  input logic [FS_W-1:0]      fault_status
);
  import lsu_pkg::*;

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dc_valid |=> !dc_valid);

  a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (req_ready && !done));

  a_r5_nc_window: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_valid && dc_load && addr_q[31:28] == NC_WINDOW) |-> dc_nc);

  a_r6_wdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !wvalid |=> (dc_wdata == '0));

  a_r7_paradox_fault: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err_paradox |=> (req_ready && !done && fault_status[FS_BIT_PARADOX]));

  a_r8_retry_waits: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err_retry |=> (st == ST_MMU && !dc_valid));

  a_r12_tlbie_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TLBIE && !mmu_done) |=> (st == ST_TLBIE && !dc_valid));
endmodule

bind lsu_ctrl_fsm lsu_ctrl_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FS_W(FS_W)) u_checks (
  .clk            (clk),
  .rst_n          (rst_n),
  .st             (st),
  .dc_valid       (dc_valid),
  .done           (done),
  .req_ready      (req_ready),
  .dc_load        (dc_load),
  .dc_nc          (dc_nc),
  .addr_q         (addr_q),
  .dc_wdata       (dc_wdata),
  .wvalid         (wvalid),
  .ev_err_paradox (ev_err_paradox),
  .ev_err_retry   (ev_err_retry),
  .mmu_done       (mmu_done),
  .fault_status   (fault_status)
);

// File: tb/tb_lsu_ctrl_fsm.sv
module tb_lsu_ctrl_fsm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0;
  logic [1:0]  req_kind = 0;
  logic [63:0] req_addr = 0;
  logic [7:0]  req_mask = 0;
  logic [63:0] req_wdata = 0;
  logic        dc_ack = 0, dc_err = 0, dc_paradox = 0;
  logic        mmu_done = 0, mmu_err = 0, mmu_invalid = 0, mmu_badtree = 0;
  logic        mmu_perm_err = 0, mmu_rc_err = 0, mmu_seg_err = 0;
  logic        req_ready, done, dc_valid, dc_load, dc_nc, mmu_req, mmu_tlbie;
  logic [63:0] dc_addr, dc_wdata, mmu_addr, fault_status, fault_addr;
  logic [7:0]  dc_sel;
  logic        exc_happened, exc_invalid, exc_badtree, exc_perm_err, exc_rc_err, exc_seg_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  lsu_ctrl_fsm dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_mask(req_mask), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .dc_valid(dc_valid), .dc_load(dc_load),
    .dc_nc(dc_nc), .dc_addr(dc_addr), .dc_sel(dc_sel), .dc_wdata(dc_wdata),
    .dc_ack(dc_ack), .dc_err(dc_err), .dc_paradox(dc_paradox),
    .mmu_req(mmu_req), .mmu_tlbie(mmu_tlbie), .mmu_addr(mmu_addr),
    .mmu_done(mmu_done), .mmu_err(mmu_err), .mmu_invalid(mmu_invalid),
    .mmu_badtree(mmu_badtree), .mmu_perm_err(mmu_perm_err), .mmu_rc_err(mmu_rc_err),
    .mmu_seg_err(mmu_seg_err), .exc_happened(exc_happened), .exc_invalid(exc_invalid),
    .exc_badtree(exc_badtree), .exc_perm_err(exc_perm_err), .exc_rc_err(exc_rc_err),
    .exc_seg_err(exc_seg_err), .fault_status(fault_status), .fault_addr(fault_addr)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [7:0]  mask;
    logic [63:0] data;
    logic        split;
    logic        nc;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 32'h0000_1000, 8'hFF, 64'h0, 1'b0, 1'b0},
    '{2'd1, 32'h0000_2004, 8'h0F, 64'h1122334455667788, 1'b0, 1'b0},
    '{2'd1, 32'h0000_3006, 8'h0F, 64'hAABBCCDDEEFF0011, 1'b1, 1'b0},
    '{2'd0, 32'hC000_0010, 8'h03, 64'h0, 1'b0, 1'b1},
    '{2'd1, 32'hC000_0020, 8'hFF, 64'h0123456789ABCDEF, 1'b0, 1'b0},
    '{2'd2, 32'h0000_4004, 8'h0F, 64'h0, 1'b0, 1'b0},
    '{2'd0, 32'hC000_0107, 8'h03, 64'h0, 1'b1, 1'b1},
    '{2'd2, 32'h0000_5005, 8'h0F, 64'h0, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic issue(input logic [1:0] kind, input logic [63:0] addr,
                       input logic [7:0] mask, input logic [63:0] data);
    @(negedge clk);
    req_valid = 1; req_kind = kind; req_addr = addr; req_mask = mask; req_wdata = data;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic ack_once();
    dc_ack = 1;
    @(negedge clk);
    dc_ack = 0;
  endtask

  task automatic run_vec(input vec_t v);
    logic [15:0]  wsel;
    logic [127:0] wdat;
    logic [2:0]   off;
    logic [63:0]  a2;
    off  = v.addr[2:0];
    wsel = '0;
    wdat = '0;
    for (int i = 0; i < 8; i++) begin
      wsel[i + off] = v.mask[i];
      wdat[(i + off) * 8 +: 8] = v.data[i * 8 +: 8];
    end
    a2 = ({32'h0, v.addr} & ~64'h7) + 64'd8;
    chk("R4 split flag", {63'b0, |wsel[15:8]}, {63'b0, v.split});
    issue(v.kind, {32'h0, v.addr}, v.mask, v.data);
    chk("R2 pulse", {63'b0, dc_valid}, 64'd1);
    chk("R2 load flag", {63'b0, dc_load}, {63'b0, v.kind != 2'd1});
    chk("R3 addr", dc_addr, {32'h0, v.addr});
    chk("R3 sel", {56'b0, dc_sel}, {56'b0, wsel[7:0]});
    chk("R5 nc", {63'b0, dc_nc}, {63'b0, v.nc});
    @(negedge clk);
    chk("R2 pulse drop", {63'b0, dc_valid}, 64'd0);
    if (v.kind == 2'd1) chk("R6 wdata lo", dc_wdata, wdat[63:0]);
    ack_once();
    if (v.split) begin
      chk("R4 gap", {63'b0, dc_valid}, 64'd0);
      @(negedge clk);
      chk("R4 second pulse", {63'b0, dc_valid}, 64'd1);
      chk("R4 second addr", dc_addr, a2);
      chk("R4 second sel", {56'b0, dc_sel}, {56'b0, wsel[15:8]});
      @(negedge clk);
      if (v.kind == 2'd1) chk("R6 wdata hi", dc_wdata, wdat[127:64]);
      ack_once();
    end else begin
      chk("R4 no second pulse", {63'b0, dc_valid}, 64'd0);
    end
    if (v.kind == 2'd2) begin
      chk("R11 writeback cycle", {63'b0, done}, 64'd0);
      @(negedge clk);
    end
    chk("R3 done", {63'b0, done}, 64'd1);
    @(negedge clk);
    chk("R3 done single", {63'b0, done}, 64'd0);
    chk("R3 ready", {63'b0, req_ready}, 64'd1);
    chk("R6 wdata idle zero", dc_wdata, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready", {63'b0, req_ready}, 64'd1);
    chk("R1 pulse", {63'b0, dc_valid}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", {63'b0, req_ready}, 64'd1);
    chk("R1 done", {63'b0, done}, 64'd0);
    chk("R1 wdata", dc_wdata, 64'd0);
    chk("R1 status", fault_status, 64'd0);
    chk("R1 faddr", fault_addr, 64'd0);

    for (int i = 0; i < 8; i++) run_vec(VECS[i]);

    // R7 paradox error on a store
    issue(2'd1, 64'h0000_7000, 8'hFF, 64'h55);
    @(negedge clk);
    dc_err = 1; dc_paradox = 1;
    #1;
    chk("R7 exc now", {63'b0, exc_happened}, 64'd1);
    chk("R7 no mmu_req", {63'b0, mmu_req}, 64'd0);
    @(negedge clk);
    dc_err = 0; dc_paradox = 0;
    chk("R7 idle", {63'b0, req_ready}, 64'd1);
    chk("R7 no done", {63'b0, done}, 64'd0);
    chk("R7 faddr", fault_addr, 64'h0000_7000);
    chk("R7 status", fault_status, (64'd1 << 25) | (64'd1 << 28));

    // R8 retry through translation
    issue(2'd0, 64'h0000_8008, 8'hFF, 64'h0);
    @(negedge clk);
    dc_err = 1;
    #1;
    chk("R8 mmu_req", {63'b0, mmu_req}, 64'd1);
    chk("R8 mmu_addr", mmu_addr, 64'h0000_8008);
    @(negedge clk);
    dc_err = 0;
    chk("R8 busy", {63'b0, req_ready}, 64'd0);
    chk("R8 mmu_req drop", {63'b0, mmu_req}, 64'd0);
    @(negedge clk);
    chk("R8 no pulse wait", {63'b0, dc_valid}, 64'd0);
    mmu_done = 1;
    @(negedge clk);
    mmu_done = 0;
    chk("R8 retry pulse", {63'b0, dc_valid}, 64'd1);
    chk("R8 retry addr", dc_addr, 64'h0000_8008);
    @(negedge clk);
    ack_once();
    chk("R8 done", {63'b0, done}, 64'd1);
    @(negedge clk);

    // R9 translation failure on a load
    issue(2'd0, 64'h0000_9010, 8'hFF, 64'h0);
    @(negedge clk);
    dc_err = 1;
    @(negedge clk);
    dc_err = 0;
    mmu_done = 1; mmu_err = 1; mmu_invalid = 1;
    #1;
    chk("R10 happened mmu", {63'b0, exc_happened}, 64'd1);
    chk("R10 invalid", {63'b0, exc_invalid}, 64'd1);
    @(negedge clk);
    mmu_done = 0; mmu_err = 0; mmu_invalid = 0;
    chk("R9 idle", {63'b0, req_ready}, 64'd1);
    chk("R9 no done", {63'b0, done}, 64'd0);
    chk("R9 faddr", fault_addr, 64'h0000_9010);
    chk("R9 status", fault_status, 64'd0);

    // R10 flags follow inputs
    mmu_badtree = 1; mmu_rc_err = 1;
    #1;
    chk("R10 badtree", {63'b0, exc_badtree}, 64'd1);
    chk("R10 rc", {63'b0, exc_rc_err}, 64'd1);
    chk("R10 perm", {63'b0, exc_perm_err}, 64'd0);
    chk("R10 happened quiet", {63'b0, exc_happened}, 64'd0);
    mmu_badtree = 0; mmu_rc_err = 0; mmu_perm_err = 1; mmu_seg_err = 1;
    #1;
    chk("R10 perm", {63'b0, exc_perm_err}, 64'd1);
    chk("R10 seg", {63'b0, exc_seg_err}, 64'd1);
    chk("R10 badtree off", {63'b0, exc_badtree}, 64'd0);
    mmu_perm_err = 0; mmu_seg_err = 0;

    // R12 TLB invalidate
    issue(2'd3, 64'h0000_A000, 8'h00, 64'h0);
    chk("R12 tlbie", {63'b0, mmu_tlbie}, 64'd1);
    chk("R12 no pulse", {63'b0, dc_valid}, 64'd0);
    repeat (3) @(negedge clk);
    chk("R12 tlbie hold", {63'b0, mmu_tlbie}, 64'd1);
    chk("R12 not done", {63'b0, done}, 64'd0);
    mmu_done = 1;
    @(negedge clk);
    mmu_done = 0;
    chk("R12 done", {63'b0, done}, 64'd1);
    chk("R12 tlbie drop", {63'b0, mmu_tlbie}, 64'd0);
    @(negedge clk);
    chk("R12 ready", {63'b0, req_ready}, 64'd1);

    // R13 request while busy is ignored
    issue(2'd0, 64'h0000_B000, 8'hFF, 64'h0);
    @(negedge clk);
    req_valid = 1; req_kind = 2'd1; req_addr = 64'h0000_C0C0; req_wdata = 64'hFF;
    @(negedge clk);
    req_valid = 0;
    chk("R13 no pulse", {63'b0, dc_valid}, 64'd0);
    chk("R13 addr kept", dc_addr, 64'h0000_B000);
    chk("R13 load kept", {63'b0, dc_load}, 64'd1);
    ack_once();
    chk("R13 done", {63'b0, done}, 64'd1);
    @(negedge clk);
    @(negedge clk);
    chk("R13 no new pulse", {63'b0, dc_valid}, 64'd0);
    chk("R13 idle", {63'b0, req_ready}, 64'd1);

    summary();
  end
endmodule